// File: doc/BRIEF.md
# Interrupt Request Qualifier and Arbiter

This block sits between a bank of active-low interrupt request lines and a processor core. Every line first passes through a clock-domain synchronizer and then a stability filter, so a line is believed only after the same value has been seen on two consecutive clock edges. The filtered lines feed a priority encoder that picks the highest-numbered active line and turns it into a binary level, where 0 means that nothing is requesting service.

The encoded level is compared with the core's current priority mask. Levels below the top level count only when they are strictly above the mask. The top level cannot be masked. The core raises a strobe when it reaches an instruction boundary or finishes exception processing. In the strobe cycle the block works out whether an eligible request exists, and on the following edge it registers a pending flag and the winning level. A request is never acted on by itself. It waits for the strobe, and it has to stay asserted until then: a line that is released falls out of the arbitration once its release has passed the filter.

Top module: `irq_qualifier`

## Requirements
- R1: Synchronous reset (active high) sets `int_pend` to 0 and `int_level` to 0 on the next edge.
- R2: A line change that then stays unchanged, applied before edge 1, with `at_boundary` high and the mask unchanged, shows at the outputs just after edge 5 and not yet after edge 4.
- R3: Line k (1 to 7) is `irq_n[k-1]` and a 0 means asserted. When several lines are asserted, `int_level` is the binary number of the highest one.
- R4: With no line asserted (level 0), `int_pend` stays 0 and `int_level` reads 0 for any mask.
- R5: A request at level 1 to 6 is reported (`int_pend`=1, `int_level`=level) only when its level is greater than `prio_mask`. When its level is less than or equal to the mask, both outputs are 0.
- R6: A level-7 request is reported for every mask value, 7 included.
- R7: The outputs are registered from the cycle in which `at_boundary` is sampled. After an edge where `at_boundary` was 0, both outputs are 0.
- R8: A line asserted for only one clock period is never reported.
- R9: A request that is released stops being reported after the same five-edge latency as in R2.
- R10: Reset clears the filter history. A line held asserted through reset is reported after edge 5 following reset release, and not after edge 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| irq_n | input | 7 | Request lines, active low; bit k-1 is level k |
| prio_mask | input | 3 | Current priority mask from the core |
| at_boundary | input | 1 | Core is at an instruction boundary or end of exception processing |
| int_pend | output | 1 | Registered: an eligible request was present in the strobe cycle |
| int_level | output | 3 | Registered: winning level, 0 when `int_pend` is 0 |

## Verification
The hardest cases to reach are the exact edge on which the filter history first accepts a value and a one-cycle glitch that must never reach the arbiter. Both are hidden behind four stages of state that cannot be observed from outside. The stimulus changes inputs on falling edges only and counts rising edges one at a time. It samples the outputs after the fourth and after the fifth edge, for a fresh assertion, for a release, and for a line held asserted through reset. For the glitch it drives a one-period pulse on the unmaskable line and watches the outputs for several cycles.

// File: rtl/irq_qual_pkg.sv
package irq_qual_pkg;

  // Width of a binary level code able to hold 0..n
  function automatic int lvl_bits(input int n);
    return $clog2(n + 1);
  endfunction

endpackage

// File: rtl/irq_line_filter.sv
module irq_line_filter #(
  parameter int SYNC_STAGES    = 2,
  parameter int STABLE_SAMPLES = 2,
  localparam int RUN_W         = $clog2(STABLE_SAMPLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic req_raw,   // active high, asynchronous to clk
  output logic req_qual   // filtered, active high
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   smp;
  logic                   prev_q;
  logic [RUN_W-1:0]       run_q;
  logic [RUN_W-1:0]       run_nxt;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= req_raw;
      end
    end else begin : g_syncn
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], req_raw};
      end
    end
  endgenerate

  assign smp = sync_q[SYNC_STAGES-1];

  // Length of the current run of identical samples, saturating
  always_comb begin
    if (smp != prev_q)
      run_nxt = RUN_W'(1);
    else if (run_q == RUN_W'(STABLE_SAMPLES))
      run_nxt = run_q;
    else
      run_nxt = run_q + RUN_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q   <= 1'b0;
      run_q    <= '0;
      req_qual <= 1'b0;
    end else begin
      prev_q <= smp;
      run_q  <= run_nxt;
      if (run_nxt == RUN_W'(STABLE_SAMPLES))
        req_qual <= smp;
    end
  end

  // A new filtered value must have been sampled on the two preceding edges
  AST_QUAL_TWO_SAMPLES: assert property (@(posedge clk) disable iff (rst)
    !$stable(req_qual) |-> ($past(smp) == req_qual) && ($past(smp, 2) == req_qual)); // R8

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int N  = 7,
  parameter int LW = 3
) (
  input  logic [N-1:0]  req_i,
  output logic [LW-1:0] lvl_o
);

  always_comb begin
    lvl_o = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i]) lvl_o = LW'(i + 1);
    end
  end

endmodule

// File: rtl/irq_mask_gate.sv
module irq_mask_gate #(
  parameter int LW      = 3,
  parameter int NMI_LVL = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [LW-1:0] lvl_in,
  input  logic [LW-1:0] mask_in,
  input  logic          chk_in,
  output logic          pend_out,
  output logic [LW-1:0] lvl_out
);

  logic eligible;

  always_comb begin
    eligible = 1'b0;
    if (lvl_in != '0)
      eligible = (lvl_in == LW'(NMI_LVL)) || (lvl_in > mask_in);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_out <= 1'b0;
      lvl_out  <= '0;
    end else begin
      pend_out <= chk_in && eligible;
      lvl_out  <= (chk_in && eligible) ? lvl_in : '0;
    end
  end

  AST_NO_PEND_OFF_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    !$past(chk_in) |-> !pend_out && (lvl_out == '0)); // R7

  AST_MASK_RESPECTED: assert property (@(posedge clk) disable iff (rst)
    (pend_out && (lvl_out != LW'(NMI_LVL))) |-> (lvl_out > $past(mask_in))); // R5

  AST_PEND_HAS_LEVEL: assert property (@(posedge clk) disable iff (rst)
    pend_out |-> (lvl_out != '0)); // R4

endmodule

// File: rtl/irq_qualifier.sv
module irq_qualifier
  import irq_qual_pkg::*;
#(
  parameter int NUM_LEVELS     = 7,
  parameter int SYNC_STAGES    = 2,
  parameter int STABLE_SAMPLES = 2,
  localparam int LVL_W         = lvl_bits(NUM_LEVELS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_LEVELS-1:0] irq_n,
  input  logic [LVL_W-1:0]      prio_mask,
  input  logic                  at_boundary,
  output logic                  int_pend,
  output logic [LVL_W-1:0]      int_level
);

  logic [NUM_LEVELS-1:0] qual;
  logic [LVL_W-1:0]      enc_lvl;

  generate
    for (genvar k = 0; k < NUM_LEVELS; k++) begin : g_line
      irq_line_filter #(
        .SYNC_STAGES    (SYNC_STAGES),
        .STABLE_SAMPLES (STABLE_SAMPLES)
      ) u_filt (
        .clk      (clk),
        .rst      (rst),
        .req_raw  (~irq_n[k]),
        .req_qual (qual[k])
      );
    end
  endgenerate

  irq_prio_enc #(
    .N  (NUM_LEVELS),
    .LW (LVL_W)
  ) u_enc (
    .req_i (qual),
    .lvl_o (enc_lvl)
  );

  irq_mask_gate #(
    .LW      (LVL_W),
    .NMI_LVL (NUM_LEVELS)
  ) u_gate (
    .clk      (clk),
    .rst      (rst),
    .lvl_in   (enc_lvl),
    .mask_in  (prio_mask),
    .chk_in   (at_boundary),
    .pend_out (int_pend),
    .lvl_out  (int_level)
  );

  AST_ENC_TOP_WINS: assert property (@(posedge clk) disable iff (rst)
    (enc_lvl != '0) |-> (qual[enc_lvl - LVL_W'(1)] && ((qual >> enc_lvl) == '0))); // R3

  AST_TOP_LEVEL_UNMASKED: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(at_boundary) && ($past(enc_lvl) == LVL_W'(NUM_LEVELS)))
      |-> (int_pend && (int_level == LVL_W'(NUM_LEVELS)))); // R6

endmodule

// File: tb/sim_irq_qualifier.sv
`timescale 1ns/1ps
module sim_irq_qualifier;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] irq_n = 7'h7F;
  logic [2:0] prio_mask = 3'd0;
  logic       at_boundary = 1'b1;
  logic       int_pend;
  logic [2:0] int_level;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  irq_qualifier u0 (
    .clk         (clk),
    .rst         (rst),
    .irq_n       (irq_n),
    .prio_mask   (prio_mask),
    .at_boundary (at_boundary),
    .int_pend    (int_pend),
    .int_level   (int_level)
  );

  // {irq_n[6:0], mask[2:0], exp_pend, exp_level[2:0]}
  localparam int NV = 12;
  localparam logic [13:0] VEC [NV] = '{
    {7'b1111111, 3'd0, 1'b0, 3'd0},  // R4 idle
    {7'b1111110, 3'd0, 1'b1, 3'd1},  // R5 level 1 over mask 0
    {7'b1111110, 3'd1, 1'b0, 3'd0},  // R5 equal to mask
    {7'b1111010, 3'd2, 1'b1, 3'd3},  // R3 lines 3 and 1
    {7'b1111010, 3'd3, 1'b0, 3'd0},  // R5 winner masked
    {7'b1011101, 3'd5, 1'b1, 3'd6},  // R3 lines 6 and 2
    {7'b0111111, 3'd7, 1'b1, 3'd7},  // R6 mask 7
    {7'b0000000, 3'd7, 1'b1, 3'd7},  // R6 R3 all lines
    {7'b0000000, 3'd6, 1'b1, 3'd7},  // R3 all lines
    {7'b1011111, 3'd6, 1'b0, 3'd0},  // R5 level 6 at mask 6
    {7'b1110111, 3'd0, 1'b1, 3'd4},  // R3 line 4
    {7'b1111111, 3'd0, 1'b0, 3'd0}   // R9 release
  };

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic ep, input logic [2:0] el);
    n_run++;
    if (int_pend !== ep || int_level !== el) begin
      n_fail++;
      $display("FAIL %s: got pend=%0b level=%0d, expected pend=%0b level=%0d",
               req, int_pend, int_level, ep, el);
    end
  endtask

  initial begin
    edges(3);
    check("R1", 1'b0, 3'd0);
    rst = 1'b0;
    edges(1);

    for (int i = 0; i < NV; i++) begin
      irq_n     = VEC[i][13:7];
      prio_mask = VEC[i][6:4];
      edges(6);
      check($sformatf("vector %0d", i), VEC[i][3], VEC[i][2:0]);
    end

    // R2: latency of a fresh assertion
    prio_mask = 3'd0;
    irq_n = 7'b1111101;
    edges(4);
    check("R2 edge4", 1'b0, 3'd0);
    edges(1);
    check("R2 edge5", 1'b1, 3'd2);

    // R9: latency of a release
    irq_n = 7'b1111111;
    edges(4);
    check("R9 edge4", 1'b1, 3'd2);
    edges(1);
    check("R9 edge5", 1'b0, 3'd0);

    // R8: one-period pulse on the top line
    irq_n = 7'b0111111;
    edges(1);
    irq_n = 7'b1111111;
    for (int c = 0; c < 8; c++) begin
      check("R8", 1'b0, 3'd0);
      edges(1);
    end

    // R7: boundary strobe gates the outputs
    irq_n = 7'b1110111;
    edges(6);
    check("R7 strobe high", 1'b1, 3'd4);
    at_boundary = 1'b0;
    edges(1);
    check("R7 strobe low", 1'b0, 3'd0);
    at_boundary = 1'b1;
    edges(1);
    check("R7 strobe pulse", 1'b1, 3'd4);
    at_boundary = 1'b0;
    edges(1);
    check("R7 after pulse", 1'b0, 3'd0);
    at_boundary = 1'b1;

    // R10 / R1: line held through reset
    irq_n = 7'b1101111;
    rst = 1'b1;
    edges(1);
    check("R1 reset", 1'b0, 3'd0);
    edges(2);
    rst = 1'b0;
    edges(4);
    check("R10 edge4", 1'b0, 3'd0);
    edges(1);
    check("R10 edge5", 1'b1, 3'd5);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got running, expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule